// File: doc/BRIEF.md
# Sub-audible tone synthesiser with PWM output

The block produces a continuous sine tone in the 67 Hz to 250.3 Hz signalling band, as a single logic-level pulse-width-modulated pin meant to feed an external low-pass filter. A free-running 8-bit period counter sets a 256-clock PWM frame. At a 2.4576 MHz clock, that frame runs at 9.6 kHz. In each frame a 16-bit frequency word is added once to a 24-bit phase register. Eight bits from the middle of that register address a 256-entry sine table. The code read from the table becomes the duty value of the following frame.

A transmit-enable input starts and stops the tone. A small index input picks the frequency word from a built-in table of tones. A second output carries one phase bit as a square wave at the tone frequency, so the tone rate can be checked on the bench without a filter.

Top module: `tone_dds_pwm`

## Requirements
- R1: The period counter runs without stopping, whether a tone is playing or not. It counts 0 to 255 and wraps, so every PWM rising edge falls on a 256-clock grid.
- R2: While a tone plays, the PWM output is high from a counter wrap until the counter equals the current duty value, which is duty clocks. It is low for the rest of the frame.
- R3: The phase register takes the frequency word added once per frame, at that frame's compare event. The phase register starts at 0 on each start, so frame n (n≥2) has duty code S(((n−1)·word >> 12) mod 256).
- R4: The sine code is S(a) = 128 + round(126·sin(2πa/256)) for a in 0..255. Every duty code lies between 1 and 254, so no frame is fully high or fully low.
- R5: Index k selects word k = floor(f_k·2^20/9600), where f_k is in hertz. The indices in ascending order are 67.0, 71.9, 77.0, 88.5, 100.0, 131.8, 186.2 and 250.3 Hz. Index 0 gives 7318, index 4 gives 10922 and index 7 gives 27339.
- R6: The phase test pin carries phase bit 19. Its period is 2^20/word frames, to within one frame (256 clocks).
- R7: A new duty value is captured after the compare event. It takes effect only at the next wrap, so no pulse changes width within a frame.
- R8: When transmit enable rises, the word is loaded, the phase is cleared and the duty is set to 128. The first pulse starts at the next counter wrap and is 128 clocks wide.
- R9: When transmit enable is low, the PWM output is low from the next clock on. The phase register, and so the test pin, hold their values.
- R10: An index of 8 or more selects the word of index 0.
- R11: While reset is asserted, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 2.4576 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | High while the tone is wanted |
| tone_sel | input | 4 | Tone index into the frequency-word table |
| pwm_o | output | 1 | Non-inverted PWM carrying the sine |
| tone_ph_o | output | 1 | Phase bit 19, a square wave at the tone frequency |

## Verification
The bound checker checks these properties on every cycle:
- The counter steps by one and wraps.
- Rising edges occur only at a wrap, and falling edges only at the compare value.
- The phase register changes only at the compare event.
- The duty value stays within 1..254 and changes only at a wrap.
- The output is off in the clock after enable drops.

Other behaviours can only be shown by the bench scenarios. A scoreboard predicts each pulse width from the phase and sine formulas and compares it with the measured pulses. The scenarios also check:
- the tone-word values for several indices, including an out-of-range one;
- the test-pin period against 2^20/word frames;
- the 128-clock first pulse;
- the frame grid staying in place across a stop and a restart.

// File: rtl/tone_dds_pkg.sv
package tone_dds_pkg;

  localparam int PWM_W    = 8;     // period counter / duty width
  localparam int ACC_W    = 24;    // phase register width
  localparam int WORD_W   = 16;    // frequency word width
  localparam int PH_LSB   = 12;    // lowest phase bit used as table address
  localparam int PH_W     = 8;     // table address width
  localparam int N_TONES  = 8;     // entries in the tone table
  localparam int SEL_W    = 4;     // tone index width
  localparam int PWM_HZ   = 9600;  // frame rate at the nominal clock
  localparam int SINE_AMP = 126;   // peak deviation from mid code

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_e;

  // Tone frequencies in tenths of a hertz, ascending.
  function automatic int tone_tenths(int k);
    case (k)
      0:       return 670;
      1:       return 719;
      2:       return 770;
      3:       return 885;
      4:       return 1000;
      5:       return 1318;
      6:       return 1862;
      7:       return 2503;
      default: return 670;
    endcase
  endfunction

  // Word = floor(f * 2^frac / rate), f in tenths of a hertz.
  function automatic longint tone_word(int k, int frac_bits, int rate_hz);
    longint num;
    num = longint'(tone_tenths(k)) << frac_bits;
    return num / (longint'(rate_hz) * 10);
  endfunction

  // Mid + round(amp * sin(2*pi*idx/n)), rounding half away from zero.
  function automatic int sine_code(int idx, int n_ent, int mid, int amp);
    real ang;
    real s;
    int  r;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(n_ent);
    s   = real'(amp) * $sin(ang);
    if (s >= 0.0) r = $rtoi(s + 0.5);
    else          r = -$rtoi(0.5 - s);
    return mid + r;
  endfunction

endpackage

// File: rtl/dds_rst_sync.sv
module dds_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/dds_period_ctr.sv
module dds_period_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ns,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap    = (cnt_q == CNT_MAX);
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cnt_q <= '0;
    else         cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/dds_tone_table.sv
module dds_tone_table
  import tone_dds_pkg::*;
#(
  parameter int N_ENT     = N_TONES,
  parameter int IDX_IN_W  = SEL_W,
  parameter int WRD_W     = WORD_W,
  parameter int FRAC_BITS = PH_LSB + PH_W,
  parameter int RATE_HZ   = PWM_HZ
) (
  input  logic [IDX_IN_W-1:0] sel_i,
  output logic [WRD_W-1:0]    word_o
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [WRD_W-1:0] tbl [N_ENT];

  for (genvar k = 0; k < N_ENT; k++) begin : g_word
    localparam longint WV = tone_word(k, FRAC_BITS, RATE_HZ);
    assign tbl[k] = WRD_W'(WV);
  end

  always_comb begin
    if (int'(sel_i) < N_ENT) word_o = tbl[sel_i[IDX_W-1:0]];
    else                     word_o = tbl[0];
  end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
  import tone_dds_pkg::*;
#(
  parameter int ADDR_W = PH_W,
  parameter int DATA_W = PWM_W,
  parameter int AMP    = SINE_AMP
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int N_ENT = 1 << ADDR_W;
  localparam int MID   = 1 << (DATA_W - 1);

  logic [DATA_W-1:0] tbl [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam int CV = sine_code(i, N_ENT, MID, AMP);
    assign tbl[i] = DATA_W'(CV);
  end

  assign data_o = tbl[addr_i];
endmodule

// File: rtl/tone_dds_pwm.sv
module tone_dds_pwm
  import tone_dds_pkg::*;
#(
  parameter int CNT_W   = PWM_W,
  parameter int PACC_W  = ACC_W,
  parameter int FW_W    = WORD_W,
  parameter int ADR_LSB = PH_LSB,
  parameter int ADR_W   = PH_W,
  parameter int NT      = N_TONES,
  parameter int TSEL_W  = SEL_W,
  parameter int RATE_HZ = PWM_HZ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [TSEL_W-1:0] tone_sel,
  output logic              pwm_o,
  output logic              tone_ph_o
);
  localparam int               ADR_MSB  = ADR_LSB + ADR_W - 1;
  localparam logic [CNT_W-1:0] DUTY_MID = CNT_W'(1 << (CNT_W - 1));

  logic              rst_ns;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wrap;
  logic              cmp_hit;
  logic [FW_W-1:0]   tbl_word;
  logic [CNT_W-1:0]  rom_code;

  tx_state_e         state_q, state_d;
  logic [FW_W-1:0]   word_q, word_d;
  logic [PACC_W-1:0] acc_q, acc_d, acc_sum;
  logic [CNT_W-1:0]  duty_q, duty_d;
  logic [CNT_W-1:0]  shad_q, shad_d;
  logic              pwm_q, pwm_d;
  logic              running;

  dds_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  dds_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_d),
    .wrap    (wrap)
  );

  dds_tone_table #(
    .N_ENT     (NT),
    .IDX_IN_W  (TSEL_W),
    .WRD_W     (FW_W),
    .FRAC_BITS (ADR_MSB + 1),
    .RATE_HZ   (RATE_HZ)
  ) u_tone (
    .sel_i  (tone_sel),
    .word_o (tbl_word)
  );

  // Phase after this frame's step; its address bits select the next duty.
  assign acc_sum = acc_q + PACC_W'(word_q);

  dds_sine_rom #(
    .ADDR_W (ADR_W),
    .DATA_W (CNT_W),
    .AMP    (SINE_AMP)
  ) u_sine (
    .addr_i (acc_sum[ADR_MSB:ADR_LSB]),
    .data_o (rom_code)
  );

  assign cmp_hit = (cnt_q == duty_q);
  assign running = (state_q == ST_RUN);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    acc_d   = acc_q;
    duty_d  = duty_q;
    shad_d  = shad_q;

    if (!tx_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_ARM;
          word_d  = tbl_word;
          acc_d   = '0;
          duty_d  = DUTY_MID;
          shad_d  = DUTY_MID;
        end
        ST_ARM: begin
          if (wrap) state_d = ST_RUN;
        end
        ST_RUN: begin
          if (cmp_hit) begin
            acc_d  = acc_sum;
            shad_d = rom_code;
          end
          if (wrap) duty_d = shad_q;
        end
        default: state_d = ST_IDLE;
      endcase
    end

    pwm_d = (state_d == ST_RUN) && (cnt_d < duty_d);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      acc_q   <= '0;
      duty_q  <= DUTY_MID;
      shad_q  <= DUTY_MID;
      pwm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      acc_q   <= acc_d;
      duty_q  <= duty_d;
      shad_q  <= shad_d;
      pwm_q   <= pwm_d;
    end
  end

  assign pwm_o     = pwm_q;
  assign tone_ph_o = acc_q[ADR_MSB];
endmodule

// File: rtl/tone_dds_pwm_chk.sv
module tone_dds_pwm_chk #(
  parameter int CNT_W  = 8,
  parameter int PACC_W = 24
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              tx_en,
  input logic              pwm_o,
  input logic              running,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  duty_q,
  input logic [PACC_W-1:0] acc_q
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] DLO  = 1;
  localparam logic [CNT_W-1:0] DHI  = CMAX - 1'b1;

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_ns)
    (cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r1_count_wrap: assert property (@(posedge clk) disable iff (!rst_ns)
    (cnt_q == CMAX) |=> (cnt_q == '0));

  a_r2_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(pwm_o) |-> (cnt_q == '0));

  a_r2_fall_at_compare: assert property (@(posedge clk) disable iff (!rst_ns)
    (running && $fell(pwm_o)) |-> (cnt_q == duty_q));

  a_r3_phase_once: assert property (@(posedge clk) disable iff (!rst_ns)
    (running && cnt_q != duty_q) |=> $stable(acc_q));

  a_r4_duty_range: assert property (@(posedge clk) disable iff (!rst_ns)
    running |-> (duty_q >= DLO && duty_q <= DHI));

  a_r7_duty_frame_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (running && $past(running) && cnt_q != '0) |-> $stable(duty_q));

  a_r9_off_when_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    !tx_en |=> !pwm_o);
endmodule

bind tone_dds_pwm tone_dds_pwm_chk #(.CNT_W(CNT_W), .PACC_W(PACC_W)) u_chk (
  .clk     (clk),
  .rst_ns  (rst_ns),
  .tx_en   (tx_en),
  .pwm_o   (pwm_o),
  .running (running),
  .cnt_q   (cnt_q),
  .duty_q  (duty_q),
  .acc_q   (acc_q)
);

// File: tb/tone_dds_pwm_tb.sv
module tone_dds_pwm_tb;

  logic       clk;
  logic       rst_n;
  logic       tx_en;
  logic [3:0] tone_sel;
  logic       pwm_o;
  logic       tone_ph_o;

  tone_dds_pwm u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tone_sel  (tone_sel),
    .pwm_o     (pwm_o),
    .tone_ph_o (tone_ph_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  localparam int WDOG = 150000;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_q[$];
  int cyc = 0;
  int hi_cnt = 0;
  bit pwm_prev = 1'b0;
  bit ph_prev = 1'b0;
  longint first_rise = -1;
  longint ph_last = -1;
  longint exp_ph = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // Reference from the requirements
  function automatic int ref_sine(int a);
    real s;
    s = 126.0 * $sin(2.0 * 3.14159265358979 * real'(a) / 256.0);
    if (s >= 0.0) return 128 + $rtoi(s + 0.5);
    else          return 128 - $rtoi(0.5 - s);
  endfunction

  function automatic int ref_word(int tenths);
    return int'((longint'(tenths) << 20) / 96000);
  endfunction

  // Monitor: pulse widths against the scoreboard, frame grid, test-pin period
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (cyc >= WDOG) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WDOG);
        finish_run();
      end
      if (pwm_o) hi_cnt++;
      if (pwm_o && !pwm_prev) begin
        if (first_rise < 0) first_rise = cyc;
        else chk(((cyc - first_rise) % 256) == 0, "R1 rise on frame grid",
                 (cyc - first_rise) % 256, 0);
      end
      if (!pwm_o && pwm_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected pulse", hi_cnt, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(hi_cnt == e, "R3 pulse width vs phase model", hi_cnt, e);
          chk(hi_cnt >= 1 && hi_cnt <= 254, "R4 width in 1..254", hi_cnt, e);
        end
        hi_cnt = 0;
      end
      if (!tx_en) ph_last = -1;
      else if (tone_ph_o && !ph_prev && exp_ph > 0) begin
        if (ph_last >= 0) begin
          longint d;
          d = (cyc - ph_last) - exp_ph;
          if (d < 0) d = -d;
          chk(d <= 256, "R6 test pin period", cyc - ph_last, exp_ph);
        end
        ph_last = cyc;
      end
      pwm_prev = pwm_o;
      ph_prev  = tone_ph_o;
    end
  end

  // Driver: push expected widths, play the tone until all are seen, then stop
  task automatic play(input int sel, input int word, input int nper, input bit ph_chk);
    exp_q.push_back(128);   // R8: first frame at mid duty
    for (int n = 2; n <= nper; n++) begin
      longint ph;
      ph = longint'(n - 1) * longint'(word);
      exp_q.push_back(ref_sine(int'((ph >> 12) & 255)));
    end
    exp_ph = ph_chk ? ((longint'(1) << 28) / word) : 0;
    @(negedge clk);
    tone_sel = sel[3:0];
    tx_en    = 1'b1;
    wait (exp_q.size() == 0);
    tx_en = 1'b0;
  endtask

  // R9: output held low and test pin frozen while idle
  task automatic idle_check(input int ncyc);
    int  highs;
    bit  ph0;
    highs = 0;
    @(negedge clk);
    ph0 = tone_ph_o;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
    chk(highs == 0, "R9 pwm low while disabled", highs, 0);
    chk(tone_ph_o == ph0, "R9 test pin holds while disabled", tone_ph_o, ph0);
  endtask

  initial begin
    rst_n    = 1'b0;
    tx_en    = 1'b0;
    tone_sel = '0;
    repeat (3) @(negedge clk);
    chk(pwm_o == 1'b0, "R11 pwm low in reset", pwm_o, 0);
    chk(tone_ph_o == 1'b0, "R11 test pin low in reset", tone_ph_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pwm_o == 1'b0, "R11 pwm low after reset, idle", pwm_o, 0);

    // R5/R6: top tone, word 27339, test-pin period about 38.35 frames
    play(7, 27339, 100, 1'b1);
    idle_check(700);

    // R5: lowest tone, word 7318
    play(0, 7318, 40, 1'b0);
    idle_check(300);

    // R10: out-of-range index falls back to entry 0
    play(12, 7318, 40, 1'b0);
    idle_check(300);

    // R5: 100.0 Hz entry, word from the formula (10922)
    chk(ref_word(1000) == 10922, "R5 100 Hz word", ref_word(1000), 10922);
    play(4, ref_word(1000), 30, 1'b0);
    idle_check(300);

    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule